// File: doc/BRIEF.md
# Table-Driven Serial Bit Correlator

The block slides a serial bit stream through a shift register of `N_BITS` stages and reports, one cycle after each accepted bit, how many window positions agree with a fixed reference pattern set by a parameter. The window is cut into four-bit groups. Each group's bits address a 16-entry table whose contents are computed at elaboration time from that group's slice of the pattern. Each entry holds the number of agreeing bits for that address. A sum stage adds the per-group scores into the final count. The datapath contains no XOR gates and no population-count logic.

A small controller has two states. `ST_FILL` is entered on reset and lasts while fewer than `N_BITS` bits have been accepted. `ST_RUN` means the window is fully populated. There is one transition, `FILL_DONE`, from `ST_FILL` to `ST_RUN`, taken when the `N_BITS`-th valid bit is accepted. Only reset leaves `ST_RUN`. The registered `window_full` output reflects `ST_RUN` in the same cycle as the count for the completing bit. A detection flag compares the count against a threshold input.

Top module: `bitcorr_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `match_count` is 0 and `window_full` and `thresh_hit` are 0.
- R2: The window shifts by one position only on a clock edge where `bit_valid` is 1. The newest bit enters window position 0 and older bits move toward position `N_BITS-1`. Window position i is compared with pattern bit i.
- R3: On the clock edge after the edge that accepted a bit, `match_count` equals `N_BITS` minus the number of window positions that differ from the pattern. The reset window is all zeros.
- R4: While `bit_valid` is 0, `match_count` does not change, whatever `bit_in` does.
- R5: `window_full` becomes 1 in the same cycle as the count for the `N_BITS`-th accepted bit after reset. It stays 1 until the next reset.
- R6: `thresh_hit` is 1 exactly when `window_full` is 1 and `match_count` is greater than or equal to `thresh`. It follows `thresh` without delay.
- R7: Each group table scores its nibble as 4 for an exact match with the pattern nibble, 3 for any one-bit difference, and correspondingly less for more differences. For a group whose pattern nibble is 1011, window nibble 1011 contributes 4, and 1010, 1001, 1111 and 0011 each contribute 3.
- R8: `match_count` never exceeds `N_BITS`. Its width is clog2(`N_BITS`+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Accept `bit_in` on this edge |
| thresh | input | clog2(N_BITS+1) | Detection threshold |
| match_count | output | clog2(N_BITS+1) | Number of agreeing positions, registered |
| thresh_hit | output | 1 | Count reaches threshold with a full window |
| window_full | output | 1 | At least `N_BITS` bits accepted since reset |

## Verification
The bench uses an 8-bit window and streams every possible byte through it, most significant bit first, so every table address in both groups is visited. A design with reversed bit order or a mis-indexed table would give wrong counts on asymmetric windows. The bench inserts idle gaps while toggling `bit_in`; a design that shifts without `bit_valid` would change the count during these gaps. The bench checks the fill boundary at the seventh and eighth bit, both after power-up and after a mid-stream reset, to catch an off-by-one in the controller. It also sweeps the threshold across the count, including 0 and values above `N_BITS`, to catch a strict instead of an inclusive compare, or a flag that ignores the fill state.

// File: rtl/bitcorr_pkg.sv
package bitcorr_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } corr_state_e;

    localparam int GROUP_BITS  = 4;
    localparam int SCORE_BITS  = 3;
    localparam int TABLE_DEPTH = 16;

    // agreement score of one nibble against its reference
    function automatic logic [SCORE_BITS-1:0] nibble_score(
        input logic [GROUP_BITS-1:0] addr,
        input logic [GROUP_BITS-1:0] ref_nib
    );
        logic [GROUP_BITS-1:0] diff;
        logic [SCORE_BITS-1:0] agree;
        diff  = addr ^ ref_nib;
        agree = SCORE_BITS'(GROUP_BITS);
        for (int b = 0; b < GROUP_BITS; b++) begin
            agree = agree - SCORE_BITS'(diff[b]);
        end
        return agree;
    endfunction

    // whole table packed flat, entry a at [a*3 +: 3]
    function automatic logic [TABLE_DEPTH*SCORE_BITS-1:0] build_table(
        input logic [GROUP_BITS-1:0] ref_nib
    );
        logic [TABLE_DEPTH*SCORE_BITS-1:0] tbl;
        tbl = '0;
        for (int a = 0; a < TABLE_DEPTH; a++) begin
            tbl[a*SCORE_BITS +: SCORE_BITS] = nibble_score(GROUP_BITS'(a), ref_nib);
        end
        return tbl;
    endfunction

endpackage

// File: rtl/corr_window.sv
module corr_window #(
    parameter int N_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [N_BITS-1:0] win
);
    // newest bit lands in position 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (shift_en) begin
            win <= {win[N_BITS-2:0], bit_in};
        end
    end
endmodule

// File: rtl/corr_nibble_lut.sv
module corr_nibble_lut
    import bitcorr_pkg::*;
#(
    parameter logic [GROUP_BITS-1:0] REF_NIB = 4'b0000
) (
    input  logic [GROUP_BITS-1:0] addr,
    output logic [SCORE_BITS-1:0] score
);
    localparam logic [TABLE_DEPTH*SCORE_BITS-1:0] TABLE = build_table(REF_NIB);

    always_comb begin
        score = TABLE[addr*SCORE_BITS +: SCORE_BITS];
    end
endmodule

// File: rtl/corr_sum.sv
module corr_sum
    import bitcorr_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int CW     = 5
) (
    input  logic [GROUPS*SCORE_BITS-1:0] parts,
    output logic [CW-1:0]                total
);
    always_comb begin
        total = '0;
        for (int g = 0; g < GROUPS; g++) begin
            total = total + CW'(parts[g*SCORE_BITS +: SCORE_BITS]);
        end
    end
endmodule

// File: rtl/bitcorr_top.sv
module bitcorr_top
    import bitcorr_pkg::*;
#(
    parameter int                N_BITS  = 16,
    parameter logic [N_BITS-1:0] PATTERN = 16'hB2D1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_in,
    input  logic                         bit_valid,
    input  logic [$clog2(N_BITS+1)-1:0]  thresh,
    output logic [$clog2(N_BITS+1)-1:0]  match_count,
    output logic                         thresh_hit,
    output logic                         window_full
);
    localparam int CW     = $clog2(N_BITS+1);
    localparam int GROUPS = N_BITS / GROUP_BITS;
    localparam int FCW    = $clog2(N_BITS);

    corr_state_e               state_q, state_d;
    logic [FCW-1:0]            fill_q;
    logic [N_BITS-1:0]         win;
    logic [GROUPS*SCORE_BITS-1:0] parts;
    logic [CW-1:0]             total;
    logic                      shifted_q;
    logic [CW-1:0]             count_q;
    logic                      full_q;

    corr_window #(.N_BITS(N_BITS)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_valid),
        .bit_in   (bit_in),
        .win      (win)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_lut
        corr_nibble_lut #(.REF_NIB(PATTERN[g*GROUP_BITS +: GROUP_BITS])) u_lut (
            .addr  (win[g*GROUP_BITS +: GROUP_BITS]),
            .score (parts[g*SCORE_BITS +: SCORE_BITS])
        );
    end

    corr_sum #(.GROUPS(GROUPS), .CW(CW)) u_sum (
        .parts (parts),
        .total (total)
    );

    // next state: FILL_DONE on the last filling bit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (bit_valid && fill_q == FCW'(N_BITS-1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // state register and fill counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL && bit_valid) begin
                fill_q <= fill_q + FCW'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shifted_q <= 1'b0;
            count_q   <= '0;
            full_q    <= 1'b0;
        end else begin
            shifted_q <= bit_valid;
            full_q    <= (state_q == ST_RUN);
            if (shifted_q) begin
                count_q <= total;
            end
        end
    end

    assign match_count = count_q;
    assign window_full = full_q;
    assign thresh_hit  = full_q && (count_q >= thresh);

endmodule

// File: rtl/bitcorr_chk.sv
module bitcorr_chk #(
    parameter int N_BITS = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bit_valid,
    input logic [$clog2(N_BITS+1)-1:0]  match_count,
    input logic                         thresh_hit,
    input logic                         window_full
);
    localparam int CW = $clog2(N_BITS+1);

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match_count <= CW'(N_BITS));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> ##1 $stable(match_count));

    assert_full_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        window_full |=> window_full);

    assert_full_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_full) |-> $past(bit_valid, 2));

    assert_hit_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_hit |-> window_full);
endmodule

bind bitcorr_top bitcorr_chk #(.N_BITS(N_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .match_count (match_count),
    .thresh_hit  (thresh_hit),
    .window_full (window_full)
);

// File: tb/sim_bitcorr_top.sv
`timescale 1ns/1ps
module sim_bitcorr_top;
    localparam int         N   = 8;
    localparam logic [7:0] PAT = 8'h4B;
    localparam int         CW  = $clog2(N+1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_in = 1'b0;
    logic          bit_valid = 1'b0;
    logic [CW-1:0] thresh = '0;
    logic [CW-1:0] match_count;
    logic          thresh_hit;
    logic          window_full;

    int errors = 0;
    int checks = 0;
    logic [7:0] mwin = '0;
    int nbits = 0;

    always #2.5 clk = ~clk;

    bitcorr_top #(.N_BITS(N), .PATTERN(PAT)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .thresh(thresh), .match_count(match_count),
        .thresh_hit(thresh_hit), .window_full(window_full)
    );

    function automatic int exp_count(input logic [7:0] w);
        return N - $countones(w ^ PAT);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int e;
        logic f;
        e = exp_count(mwin);
        f = (nbits >= N);
        chk({req, " count"}, int'(match_count), e);
        chk({req, " full"}, int'(window_full), int'(f));
        chk({req, " hit"}, int'(thresh_hit), int'(f && (e >= int'(thresh))));
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        mwin = {mwin[6:0], b};
        nbits++;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input string req);
        for (int i = 7; i >= 0; i--) begin
            send(v[i]);
            check_all(req);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 count in reset", int'(match_count), 0);
        chk("R1 full in reset", int'(window_full), 0);
        chk("R1 hit in reset", int'(thresh_hit), 0);
        rst_n = 1'b1;
        mwin = '0;
        nbits = 0;
        @(negedge clk);
        chk("R1 count after reset", int'(match_count), 0);
        chk("R1 full after reset", int'(window_full), 0);
        chk("R1 hit after reset", int'(thresh_hit), 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        thresh = CW'(5);
        do_reset();

        // fill boundary: seven bits not full, eighth full (R5)
        for (int i = 0; i < 7; i++) begin
            send(1'b1);
            check_all("R5 fill");
        end
        send(1'b0);
        check_all("R5 fill done");

        // every window value, MSB first (R2 R3)
        for (int v = 0; v < 256; v++) begin
            send_byte(8'(v), "R3 sweep");
            if (v % 37 == 0) begin
                // idle with toggling data (R4)
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    bit_in = ~bit_in;
                end
                @(negedge clk);
                check_all("R4 idle");
            end
        end

        // order check: asymmetric window 0000_0001 (R2)
        send_byte(8'h01, "R2 order");
        chk("R2 newest at bit0", int'(match_count), exp_count(8'h01));

        // table entries for nibble 1011 (R7)
        send_byte(8'h4B, "R7 exact");
        chk("R7 exact 1011", int'(match_count), 8);
        send_byte(8'h4A, "R7 one-off");
        chk("R7 1010", int'(match_count), 7);
        send_byte(8'h49, "R7 one-off");
        chk("R7 1001", int'(match_count), 7);
        send_byte(8'h4F, "R7 one-off");
        chk("R7 1111", int'(match_count), 7);
        send_byte(8'h43, "R7 one-off");
        chk("R7 0011", int'(match_count), 7);

        // threshold sweep around a count of 7 (R6)
        for (int t = 0; t < (1 << CW); t++) begin
            @(negedge clk);
            thresh = CW'(t);
            #1;
            chk("R6 thresh sweep", int'(thresh_hit), int'(7 >= t));
        end
        thresh = CW'(5);

        // bound at full agreement (R8)
        send_byte(8'h4B, "R8 max");
        chk("R8 max count", int'(match_count), N);

        // mid-stream reset then refill (R1 R5)
        send(1'b1);
        do_reset();
        thresh = CW'(0);
        for (int i = 0; i < 7; i++) begin
            send(1'(i));
            check_all("R5 refill");
        end
        send(1'b1);
        check_all("R5 refill done");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule